// File: doc/BRIEF.md
# Macropixel Sparsified Readout Controller

This block is the periphery readout logic of a pixel matrix organised as 4x4-pixel macropixels. Each macropixel has two private lines to the periphery. The macropixel drives a hit flag to the controller, and the controller drives a freeze line back to the macropixel. When a hit flag is seen, the controller freezes that macropixel and records the current bunch-crossing timestamp for it. It then serves frozen macropixels one at a time. For each one it raises one shared column enable and one shared row enable, samples the 16-bit hit pattern from the common data bus, and emits one formatted word per hit pixel on a valid/ready output.

Everything runs on the fast readout clock. The crossing clock reaches the block as a one-cycle tick, already synchronised, and each tick advances an internal timestamp counter. A macropixel stays frozen until its last word has been accepted. Hits that land on it in the meantime stay inside the matrix. After release they raise the flag again and are tagged with the later timestamp.

Top module: `mpx_readout_top`

## Requirements
- R1: After reset, out_valid, every col_en and row_en bit and every mp_frz bit are low, and the timestamp counter is zero.
- R2: A macropixel whose mp_hit bit is high at a clock edge while its mp_frz bit is low has its mp_frz bit high from that edge on.
- R3: The timestamp advances by one, modulo 2^TS_W, at every edge where xing_tick is high. A macropixel is tagged with the value held in the cycle in which it was frozen.
- R4: The macropixel with index i = column*N_ROWS + row (bit i of mp_hit and mp_frz) is served before every frozen macropixel of higher index. The choice is made from the set frozen in the cycle before its capture.
- R5: A capture lasts one cycle. In it exactly one col_en bit and one row_en bit are high, naming the macropixel served, and mp_data is sampled at the closing edge. In every other cycle both enable vectors are zero.
- R6: A captured pattern yields one output word per set bit, in ascending pixel index. Clear bits yield nothing.
- R7: An output word is {timestamp, macropixel row, macropixel column, pixel index}. With the default parameters these are bits [15:8], [7:6], [5:4] and [3:0].
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value. No word is lost or repeated.
- R9: The mp_frz bit of a macropixel falls at the edge that accepts its last word, and at most one bit falls per cycle.
- R10: An mp_hit bit that is high while its macropixel is frozen is ignored. If the bit is still high after release, the macropixel is frozen again with the timestamp of that later cycle.
- R11: A captured all-zero pattern emits no word and releases the macropixel at the capture edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Synchronous reset, active low |
| xing_tick | input | 1 | One-cycle pulse per bunch crossing |
| mp_hit | input | N_COLS*N_ROWS | Private hit flag from each macropixel |
| mp_frz | output | N_COLS*N_ROWS | Private freeze line to each macropixel |
| col_en | output | N_COLS | Shared column enable |
| row_en | output | N_ROWS | Shared row enable |
| mp_data | input | 16 | Shared pixel pattern bus |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | TS_W+clog2(N_ROWS)+clog2(N_COLS)+4 | Formatted hit word |

## Verification
The checker watches several properties on every cycle. It checks that the enables are one-hot and paired, that an unfrozen flagged macropixel is frozen at the next edge, that releases come one at a time, that each tick steps the counter, and that words stay stable under backpressure. The bench's behavioural model is needed for the rest. Only it can show that the service order follows index priority, that each word carries the right timestamp after counter wrap and after a release-and-refreeze, that pixel order is ascending, and that an empty capture produces no word.

// File: rtl/mpx_pkg.sv
// Shared definitions for the macropixel readout controller.
// Assumes a fixed 4x4 macropixel, so a pattern is 16 bits and a pixel index 4 bits.
package mpx_pkg;
    localparam int PIX_PER_MP = 16;
    localparam int PIX_W      = 4;

    typedef enum logic [1:0] {
        SC_IDLE = 2'd0,
        SC_CAP  = 2'd1,
        SC_EMIT = 2'd2
    } scan_state_t;
endpackage

// File: rtl/mpx_ts_counter.sv
// Crossing timestamp counter.
// Advances by one per readout-clock cycle in which tick_i is high; wraps naturally.
// Assumes tick_i is already synchronous to clk.
module mpx_ts_counter #(
    parameter int TS_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_i,
    output logic [TS_W-1:0] ts_o
);
    // Count crossings.
    always_ff @(posedge clk) begin
        if (!rst_n)      ts_o <= '0;
        else if (tick_i) ts_o <= ts_o + 1'b1;
    end
endmodule

// File: rtl/mpx_hit_latch.sv
// Per-macropixel hit register and timestamp store.
// A flagged, unfrozen macropixel is frozen and tagged with ts_i. It stays frozen
// until the scan releases it. Flags seen while frozen are ignored.
// Assumes release only targets a frozen macropixel, at most one per cycle.
module mpx_hit_latch #(
    parameter int N_MP  = 16,
    parameter int IDX_W = 4,
    parameter int TS_W  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_MP-1:0]  hit_i,
    input  logic [TS_W-1:0]  ts_i,
    input  logic             rel_i,
    input  logic [IDX_W-1:0] rel_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [N_MP-1:0]  pend_o,
    output logic [TS_W-1:0]  rd_ts_o
);
    logic [TS_W-1:0] ts_arr [N_MP];

    for (genvar i = 0; i < N_MP; i++) begin : g_mp
        logic            pend_q;
        logic [TS_W-1:0] ts_q;

        // Freeze on a new flag, release on scan completion.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend_q <= 1'b0;
                ts_q   <= '0;
            end else if (!pend_q && hit_i[i]) begin
                pend_q <= 1'b1;
                ts_q   <= ts_i;
            end else if (rel_i && rel_idx_i == IDX_W'(i)) begin
                pend_q <= 1'b0;
            end
        end

        assign pend_o[i] = pend_q;
        assign ts_arr[i] = ts_q;
    end

    assign rd_ts_o = ts_arr[rd_idx_i];
endmodule

// File: rtl/mpx_pick.sv
// Fixed-priority picker: the lowest set index of req_i wins.
// Index order is column-major, so the lowest column wins first, then the lowest row.
module mpx_pick #(
    parameter int N_MP  = 16,
    parameter int IDX_W = 4
) (
    input  logic [N_MP-1:0]  req_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan from the top so the lowest request overrides.
    always_comb begin
        idx_o = '0;
        for (int i = N_MP - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    assign any_o = |req_i;
endmodule

// File: rtl/mpx_scan.sv
// Readout scan and sparsifier.
// IDLE picks a frozen macropixel. CAP enables it for one cycle and samples the bus.
// EMIT sends one word per set pixel, lowest first, and holds under backpressure.
// The macropixel is released with its last accepted word, or at CAP if the pattern is empty.
module mpx_scan
    import mpx_pkg::*;
#(
    parameter int N_COLS = 4,
    parameter int N_ROWS = 4,
    parameter int TS_W   = 8
) (
    clk, rst_n, any_i, pick_idx_i, pick_ts_i, mp_data_i, out_ready_i,
    col_en_o, row_en_o, out_valid_o, out_data_o, rel_o, rel_idx_o
);
    localparam int N_MP   = N_COLS * N_ROWS;
    localparam int IDX_W  = $clog2(N_MP);
    localparam int COL_W  = $clog2(N_COLS);
    localparam int ROW_W  = $clog2(N_ROWS);
    localparam int WORD_W = TS_W + ROW_W + COL_W + PIX_W;

    input  logic                  clk;
    input  logic                  rst_n;
    input  logic                  any_i;
    input  logic [IDX_W-1:0]      pick_idx_i;
    input  logic [TS_W-1:0]       pick_ts_i;
    input  logic [PIX_PER_MP-1:0] mp_data_i;
    input  logic                  out_ready_i;
    output logic [N_COLS-1:0]     col_en_o;
    output logic [N_ROWS-1:0]     row_en_o;
    output logic                  out_valid_o;
    output logic [WORD_W-1:0]     out_data_o;
    output logic                  rel_o;
    output logic [IDX_W-1:0]      rel_idx_o;

    scan_state_t           state;
    logic [IDX_W-1:0]      cur_idx;
    logic [TS_W-1:0]       cur_ts;
    logic [PIX_PER_MP-1:0] pat;
    logic [PIX_W-1:0]      pix;
    logic [PIX_PER_MP-1:0] pat_rest;
    logic [COL_W-1:0]      cur_col;
    logic [ROW_W-1:0]      cur_row;
    logic                  last_word;

    // Lowest set pixel of the held pattern.
    always_comb begin
        pix = '0;
        for (int b = PIX_PER_MP - 1; b >= 0; b--) begin
            if (pat[b]) pix = PIX_W'(b);
        end
    end

    assign pat_rest  = pat & ~(PIX_PER_MP'(1) << pix);
    assign last_word = (pat_rest == '0);
    assign cur_col   = COL_W'(32'(cur_idx) / N_ROWS);
    assign cur_row   = ROW_W'(32'(cur_idx) % N_ROWS);

    // Scan sequencing and pattern consumption.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SC_IDLE;
            cur_idx <= '0;
            cur_ts  <= '0;
            pat     <= '0;
        end else begin
            case (state)
                SC_IDLE: if (any_i) begin
                    cur_idx <= pick_idx_i;
                    cur_ts  <= pick_ts_i;
                    state   <= SC_CAP;
                end
                SC_CAP: begin
                    pat   <= mp_data_i;
                    state <= (mp_data_i == '0) ? SC_IDLE : SC_EMIT;
                end
                SC_EMIT: if (out_ready_i) begin
                    pat <= pat_rest;
                    if (last_word) state <= SC_IDLE;
                end
                default: state <= SC_IDLE;
            endcase
        end
    end

    // Shared enables, active only in the capture cycle.
    for (genvar c = 0; c < N_COLS; c++) begin : g_col
        assign col_en_o[c] = (state == SC_CAP) && (cur_col == COL_W'(c));
    end
    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
        assign row_en_o[r] = (state == SC_CAP) && (cur_row == ROW_W'(r));
    end

    assign out_valid_o = (state == SC_EMIT);
    assign out_data_o  = {cur_ts, cur_row, cur_col, pix};
    assign rel_o       = ((state == SC_CAP) && (mp_data_i == '0)) ||
                         ((state == SC_EMIT) && out_ready_i && last_word);
    assign rel_idx_o   = cur_idx;
endmodule

// File: rtl/mpx_readout_top.sv
// Top of the macropixel sparsified readout controller.
// Ties the crossing counter, the per-macropixel hit register, the priority picker and
// the scan together. Assumes one readout clock, a synchronous crossing tick, and a
// matrix that drives mp_data from the macropixel whose column and row are both enabled.
module mpx_readout_top #(
    parameter int N_COLS = 4,
    parameter int N_ROWS = 4,
    parameter int TS_W   = 8
) (
    input  logic                                               clk,
    input  logic                                               rst_n,
    input  logic                                               xing_tick,
    input  logic [N_COLS*N_ROWS-1:0]                           mp_hit,
    output logic [N_COLS*N_ROWS-1:0]                           mp_frz,
    output logic [N_COLS-1:0]                                  col_en,
    output logic [N_ROWS-1:0]                                  row_en,
    input  logic [15:0]                                        mp_data,
    output logic                                               out_valid,
    input  logic                                               out_ready,
    output logic [TS_W+$clog2(N_ROWS)+$clog2(N_COLS)+4-1:0]    out_data
);
    localparam int N_MP  = N_COLS * N_ROWS;
    localparam int IDX_W = $clog2(N_MP);

    logic [TS_W-1:0]  ts_now;
    logic [TS_W-1:0]  pick_ts;
    logic [IDX_W-1:0] pick_idx;
    logic [IDX_W-1:0] rel_idx;
    logic             pick_any;
    logic             rel;

    mpx_ts_counter #(.TS_W(TS_W)) u_ts (
        .clk(clk), .rst_n(rst_n), .tick_i(xing_tick), .ts_o(ts_now)
    );

    mpx_hit_latch #(.N_MP(N_MP), .IDX_W(IDX_W), .TS_W(TS_W)) u_hits (
        .clk(clk), .rst_n(rst_n), .hit_i(mp_hit), .ts_i(ts_now),
        .rel_i(rel), .rel_idx_i(rel_idx), .rd_idx_i(pick_idx),
        .pend_o(mp_frz), .rd_ts_o(pick_ts)
    );

    mpx_pick #(.N_MP(N_MP), .IDX_W(IDX_W)) u_pick (
        .req_i(mp_frz), .any_o(pick_any), .idx_o(pick_idx)
    );

    mpx_scan #(.N_COLS(N_COLS), .N_ROWS(N_ROWS), .TS_W(TS_W)) u_scan (
        .clk(clk), .rst_n(rst_n), .any_i(pick_any), .pick_idx_i(pick_idx),
        .pick_ts_i(pick_ts), .mp_data_i(mp_data), .out_ready_i(out_ready),
        .col_en_o(col_en), .row_en_o(row_en), .out_valid_o(out_valid),
        .out_data_o(out_data), .rel_o(rel), .rel_idx_o(rel_idx)
    );
endmodule

// File: rtl/mpx_readout_chk.sv
// Cycle-level properties of the readout controller, bound into the top.
module mpx_readout_chk #(
    parameter int N_COLS = 4,
    parameter int N_ROWS = 4,
    parameter int TS_W   = 8,
    parameter int WORD_W = 16
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     xing_tick,
    input logic [N_COLS*N_ROWS-1:0] mp_hit,
    input logic [N_COLS*N_ROWS-1:0] mp_frz,
    input logic [N_COLS-1:0]        col_en,
    input logic [N_ROWS-1:0]        row_en,
    input logic                     out_valid,
    input logic                     out_ready,
    input logic [WORD_W-1:0]        out_data,
    input logic [TS_W-1:0]          ts_now
);
    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R5
    col_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(col_en));

    // R5
    row_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(row_en));

    // R5
    en_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(col_en) == $countones(row_en));

    // R2
    freeze_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(mp_hit & ~mp_frz) |=> (($past(mp_hit) & ~$past(mp_frz)) & ~mp_frz) == '0);

    // R9
    single_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones($past(mp_frz) & ~mp_frz) <= 1);

    // R3
    ts_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xing_tick |=> ts_now == TS_W'($past(ts_now) + 1'b1));

    // R9
    emit_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> mp_frz != '0);
endmodule

bind mpx_readout_top mpx_readout_chk #(
    .N_COLS(N_COLS), .N_ROWS(N_ROWS), .TS_W(TS_W),
    .WORD_W(TS_W + $clog2(N_ROWS) + $clog2(N_COLS) + 4)
) u_chk (
    .clk(clk), .rst_n(rst_n), .xing_tick(xing_tick), .mp_hit(mp_hit),
    .mp_frz(mp_frz), .col_en(col_en), .row_en(row_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .ts_now(ts_now)
);

// File: tb/mpx_readout_top_tb.sv
`timescale 1ns/1ps
// Bench: a behavioural matrix and a reference model, both updated at every falling edge.
module mpx_readout_top_tb;
    localparam int NC = 4, NR = 4, NM = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xing_tick = 1'b0;
    logic [15:0] mp_hit = '0;
    logic [15:0] mp_frz;
    logic [3:0]  col_en, row_en;
    logic [15:0] mp_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    always #4 clk = ~clk;

    mpx_readout_top #(.N_COLS(NC), .N_ROWS(NR), .TS_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .xing_tick(xing_tick), .mp_hit(mp_hit),
        .mp_frz(mp_frz), .col_en(col_en), .row_en(row_en), .mp_data(mp_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    // Matrix state, stimulus requests and model state
    logic [15:0] pat [NM];
    logic [15:0] held [NM];
    logic [15:0] inj [NM];
    logic [15:0] spur = '0;
    logic [15:0] mpend = '0, mpend_prev = '0;
    int          mts [NM];
    int          ts_model = 0;
    int          q_data [$];
    int          q_idx [$];
    bit          q_last [$];
    int          checks = 0, errors = 0, ncyc = 0;
    int          rmode = 0, tdiv = 0, mp10_words = 0;
    logic        p_valid = 0, p_ready = 0, p_tick = 0;
    logic [15:0] p_hit = '0, p_frz = '0, p_data = '0;
    logic [3:0]  p_col = '0, p_row = '0;

    // Shared data bus driven by the enabled macropixel
    always_comb begin
        mp_data = '0;
        for (int c = 0; c < NC; c++)
            for (int r = 0; r < NR; r++)
                if (col_en[c] && row_en[r]) mp_data = pat[c*NR + r];
    end

    function automatic int lowest(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return i;
        return -1;
    endfunction

    function automatic int onehot_idx(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return -1;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, ncyc);
        end
    endtask

    // One clock: evaluate the edge just passed, then drive the next cycle
    task automatic cycle();
        logic [15:0] rel, lat;
        @(negedge clk);
        ncyc++;
        rel = '0;
        lat = '0;
        if (p_valid && p_ready) begin
            if (q_data.size() == 0) begin
                chk(0, "R6 unexpected word", p_data, 0);
            end else begin
                int ed, ei;
                bit el;
                ed = q_data.pop_front();
                ei = q_idx.pop_front();
                el = q_last.pop_front();
                chk(p_data == 16'(ed), "R3 R6 R7 word", p_data, ed);
                if (el) rel[ei] = 1'b1;
            end
            if ((int'(p_data[5:4]) * NR + int'(p_data[7:6])) == 10) mp10_words++;
        end
        if (p_col != '0 || p_row != '0) begin
            int c, r, sel;
            c = onehot_idx(p_col);
            r = onehot_idx(p_row);
            sel = c * NR + r;
            chk($countones(p_col) == 1 && $countones(p_row) == 1, "R5 enable one-hot",
                {p_col, p_row}, 0);
            chk(sel == lowest(mpend_prev), "R4 R5 service order", sel, lowest(mpend_prev));
            if (pat[sel] == '0) rel[sel] = 1'b1;
            for (int b = 0; b < 16; b++) begin
                if (pat[sel][b]) begin
                    q_data.push_back(((mts[sel] & 255) << 8) | (r << 6) | (c << 4) | b);
                    q_idx.push_back(sel);
                    q_last.push_back((pat[sel] >> (b + 1)) == 16'd0);
                end
            end
        end
        for (int i = 0; i < NM; i++) begin
            if (p_hit[i] && !mpend[i]) begin
                lat[i] = 1'b1;
                mts[i] = ts_model;
            end
        end
        mpend_prev = mpend;
        mpend = (mpend | lat) & ~rel;
        if (p_tick) ts_model = (ts_model + 1) & 255;
        chk(mp_frz == mpend, "R2 R9 R10 freeze mask", mp_frz, mpend);
        if (p_valid && !p_ready)
            chk(out_valid && out_data == p_data, "R8 hold under backpressure",
                out_data, p_data);
        // matrix: release swaps in held hits; new hits go to held while frozen
        for (int i = 0; i < NM; i++) begin
            if (p_frz[i] && !mp_frz[i]) begin
                pat[i] = held[i];
                held[i] = '0;
            end
            if (inj[i] != '0) begin
                if (mp_frz[i]) held[i] = held[i] | inj[i];
                else           pat[i]  = pat[i] | inj[i];
                inj[i] = '0;
            end
        end
        for (int i = 0; i < NM; i++) mp_hit[i] = (pat[i] != '0) | spur[i];
        spur = '0;
        case (rmode)
            0: out_ready = 1'b1;
            1: out_ready = ncyc[0];
            default: out_ready = (ncyc % 4 == 0);
        endcase
        xing_tick = (tdiv != 0) && (ncyc % tdiv == 0);
        p_valid = out_valid; p_ready = out_ready; p_tick = xing_tick;
        p_hit = mp_hit; p_frz = mp_frz; p_data = out_data;
        p_col = col_en; p_row = row_en;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) cycle();
    endtask

    task automatic drain();
        for (int k = 0; k < 3000; k++) begin
            if (q_data.size() == 0 && mpend == '0 && mp_hit == '0 && !out_valid) break;
            cycle();
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", ncyc, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int lfsr;
        for (int i = 0; i < NM; i++) begin
            pat[i] = '0; held[i] = '0; inj[i] = '0; mts[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!out_valid && col_en == '0 && row_en == '0 && mp_frz == '0, "R1 reset outputs",
            {out_valid, col_en, row_en}, 0);
        // R1: a hit before any crossing carries timestamp zero
        inj[5] = 16'h8421;
        run(30);
        // R4: simultaneous hits served by index; crossings every 12 cycles
        tdiv = 12;
        inj[14] = 16'h0003; inj[3] = 16'h1000; inj[9] = 16'h00F0; inj[0] = 16'h0101;
        run(60);
        // R8: full patterns under heavy backpressure
        rmode = 2;
        inj[2] = 16'hFFFF; inj[12] = 16'hFFFF;
        run(200);
        drain();
        // R10: more hits on a frozen macropixel are held and retagged later
        rmode = 2;
        inj[7] = 16'h0F0F;
        run(3);
        inj[7] = 16'h2000;
        run(20);
        inj[7] = 16'h0010;
        drain();
        // R11: flag with an empty pattern emits nothing
        rmode = 0;
        mp10_words = 0;
        spur[10] = 1'b1;
        run(12);
        chk(mp10_words == 0 && mp_frz[10] == 1'b0, "R11 empty capture", mp10_words, 0);
        // R3: fast crossings to wrap the timestamp
        tdiv = 1;
        for (int k = 0; k < 30; k++) begin
            inj[k % NM] = 16'(1 << (k % 16));
            run(11);
        end
        drain();
        // Mixed traffic
        tdiv = 7;
        lfsr = 32'h1ACE5EED;
        for (int k = 0; k < 3000; k++) begin
            lfsr = (lfsr << 1) ^ ((lfsr < 0) ? 32'h04C11DB7 : 0);
            rmode = (k / 500) % 3;
            if ((lfsr & 7) == 0) inj[(lfsr >> 4) & 15] = 16'(lfsr >> 12);
            cycle();
        end
        drain();
        chk(q_data.size() == 0 && mp_frz == '0, "R6 R9 all words delivered",
            q_data.size(), 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule